// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Selectable Count Source

This block is an 8-bit up-counter for a microcontroller-style peripheral. A 3-bit source field in the control register picks what advances the count. It can be stopped, step on every system clock, step on a divided system clock, or step on one chosen edge of an external count pin. The divided rates come from one free-running 10-bit divider. That divider gives one-cycle step enables, not derived clocks. The external pin passes through a two-flop synchronizer before its edges are detected, so the count moves at most once per system clock.

The block raises two events. A wrap from 0xFF to 0x00 sets an overflow flag. A counting step that brings the count to the compare value sets a compare flag and can also drive a compare output pin, with no processor action. Each flag has its own enable, which gates a level interrupt line. A flag clears when its acknowledge input pulses (interrupt taken) or when software writes a 1 to it. Software reaches the control, count, compare and flag registers through a simple write port and an address-selected combinational read port. The counter runs in plain wrap-around mode only.

Top module: `tmr8_unit`

## Requirements
- R1: With source code 000 the count holds its value, whatever the prescaler and the external pin do.
- R2: With source code 001 the count advances by one on every system clock.
- R3: Source codes 010, 011, 100 and 101 advance the count once per 8, 64, 256 and 1024 system clocks. So any window of N clocks, with N a multiple of the ratio, taken after the code is written, adds exactly N/ratio steps.
- R4: Source code 111 counts rising edges and code 110 counts falling edges of the external count pin. The pin is sampled through two flops, and each edge gives exactly one step.
- R5: A step taken from a count of 0xFF gives 0x00 and sets the overflow flag, which is bit 0 of the flag register.
- R6: A step that brings the count equal to the compare register sets the compare flag, which is bit 1 of the flag register.
- R7: Writing the flag register with a 1 in a bit position clears that flag, and a 0 leaves it alone. A one-cycle pulse on ovf_ack or cmp_ack clears the matching flag. A flag set in the same cycle as its clear stays set.
- R8: ovf_irq is high exactly when the overflow flag and control bit 5 are both set. cmp_irq is high exactly when the compare flag and control bit 6 are both set.
- R9: Control bits [4:3] give the compare-pin action on a match: 01 toggle, 10 drive low, 11 drive high. With 00 the pin reads 0, and its held state does not change on a match; it shows again when an action mode is selected.
- R10: A write to the count register lands even when a step is due in the same cycle, and that step then sets neither the overflow flag nor the compare flag.
- R11: The registers are placed as follows, and all reset to zero:
  - address 0 is control: [2:0] source, [4:3] pin action, [5] overflow enable, [6] compare enable; bit 7 reads 0.
  - address 1 is the count.
  - address 2 is the compare value.
  - address 3 is the flags; bits [7:2] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data for rd_addr |
| ext_cnt_pin | input | 1 | External count pin, asynchronous |
| ovf_ack | input | 1 | Overflow interrupt taken, clears the flag |
| cmp_ack | input | 1 | Compare interrupt taken, clears the flag |
| cmp_pin | output | 1 | Compare output pin |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The bench sweeps every source code. Each divided rate gets a 1024-clock window, which is a whole number of periods for every ratio, so the expected step count does not depend on the divider's phase, and a wrong ratio or a swapped code shows up as a different count. Pulse trains on the external pin are counted in the stopped, rising and falling modes, which tells edge polarity and synchronizer double counting apart. Runs that start just below 0xFF and just below the compare value show the exact cycle in which each flag rises. A count write and an acknowledge are each placed on the very edge of an event, which separates the write and clear priorities. A sequence of matches through every pin action, including the disconnected mode, tells toggle, drive and hold apart.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [2:0] {
    SRC_STOP     = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pin_act_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int NUM_TAPS = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic [tmr8_pkg::NUM_TAPS-1:0] tick_o
);
  localparam int TAP_BITS [tmr8_pkg::NUM_TAPS] = '{3, 6, 8, 10};

  logic [PRE_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  generate
    for (genvar i = 0; i < tmr8_pkg::NUM_TAPS; i++) begin : g_tap
      localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << TAP_BITS[i]) - 1);
      assign tick_o[i] = ((div_q & MASK) == MASK);
    end
  endgenerate

  // R3
  tick8_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[1] & ~sync_q[2];
  assign fall_o = ~sync_q[1] & sync_q[2];

  // R4
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_step_sel.sv
module tmr_step_sel
  import tmr8_pkg::*;
(
  input  src_sel_e              src_i,
  input  logic [NUM_TAPS-1:0]   tick_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  output logic                  step_o
);
  always_comb begin
    unique case (src_i)
      SRC_STOP:     step_o = 1'b0;
      SRC_DIV1:     step_o = 1'b1;
      SRC_DIV8:     step_o = tick_i[0];
      SRC_DIV64:    step_o = tick_i[1];
      SRC_DIV256:   step_o = tick_i[2];
      SRC_DIV1024:  step_o = tick_i[3];
      SRC_PIN_FALL: step_o = fall_i;
      SRC_PIN_RISE: step_o = rise_i;
      default:      step_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_cnt_pin,
  input  logic             ovf_ack,
  input  logic             cmp_ack,
  output logic             cmp_pin,
  output logic             ovf_irq,
  output logic             cmp_irq
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0]  ocr_q, ocr_d;
  logic              ovf_q, ovf_d, cmp_q, cmp_d, oc_q, oc_d;

  logic [NUM_TAPS-1:0] tick;
  logic                pin_rise, pin_fall, step;
  logic                ctrl_wr, cnt_wr, ocr_wr, flag_wr;
  logic                step_go, ovf_set, cmp_hit;
  src_sel_e            src;
  pin_act_e            act;

  assign src = src_sel_e'(ctrl_q[2:0]);
  assign act = pin_act_e'(ctrl_q[4:3]);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tmr_pin_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_cnt_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  tmr_step_sel u_sel (
    .src_i  (src),
    .tick_i (tick),
    .rise_i (pin_rise),
    .fall_i (pin_fall),
    .step_o (step)
  );

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    cnt_wr  = wr_en && (wr_addr == ADDR_CNT);
    ocr_wr  = wr_en && (wr_addr == ADDR_CMP);
    flag_wr = wr_en && (wr_addr == ADDR_FLAG);

    step_go = step && !cnt_wr;
    cnt_inc = cnt_q + 1'b1;
    ovf_set = step_go && (cnt_q == {CNT_W{1'b1}});
    cmp_hit = step_go && (cnt_inc == ocr_q);

    ctrl_d = ctrl_wr ? wr_data[CTRL_W-1:0] : ctrl_q;
    ocr_d  = ocr_wr ? wr_data : ocr_q;

    if (cnt_wr)       cnt_d = wr_data;
    else if (step_go) cnt_d = cnt_inc;
    else              cnt_d = cnt_q;

    ovf_d = ovf_set | (ovf_q & ~ovf_ack & ~(flag_wr & wr_data[0]));
    cmp_d = cmp_hit | (cmp_q & ~cmp_ack & ~(flag_wr & wr_data[1]));

    oc_d = oc_q;
    if (cmp_hit) begin
      unique case (act)
        PIN_TOGGLE: oc_d = ~oc_q;
        PIN_LOW:    oc_d = 1'b0;
        PIN_HIGH:   oc_d = 1'b1;
        default:    oc_d = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ocr_q  <= '0;
      ovf_q  <= 1'b0;
      cmp_q  <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      ocr_q  <= ocr_d;
      ovf_q  <= ovf_d;
      cmp_q  <= cmp_d;
      oc_q   <= oc_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL: rd_data = CNT_W'(ctrl_q);
      ADDR_CNT:  rd_data = cnt_q;
      ADDR_CMP:  rd_data = ocr_q;
      default:   rd_data = CNT_W'({cmp_q, ovf_q});
    endcase
  end

  assign cmp_pin = (act != PIN_OFF) && oc_q;
  assign ovf_irq = ovf_q && ctrl_q[5];
  assign cmp_irq = cmp_q && ctrl_q[6];

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STOP && !cnt_wr) |=> $stable(cnt_q));

  // R5
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0));

  // R6
  cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_q) |-> (cnt_q == $past(ocr_q)));

  // R7
  ovf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack && !ovf_set) |=> !ovf_q);

  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_hit |=> $stable(oc_q));

  // R10
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data) && !$rose(ovf_q) && !$rose(cmp_q)));
endmodule

// File: tb/tmr8_unit_test.sv
module tmr8_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_cnt_pin = 1'b0;
  logic       ovf_ack = 1'b0;
  logic       cmp_ack = 1'b0;
  logic       cmp_pin, ovf_irq, cmp_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr8_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_cnt_pin(ext_cnt_pin), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
    .cmp_pin(cmp_pin), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_cnt_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_cnt_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic match_once(input logic [1:0] mode);
    wr(2'd0, {3'b000, mode, 3'd0});
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h7F);
    wr(2'd0, {3'b000, mode, 3'd1});
    wr(2'd0, {3'b000, mode, 3'd0});
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int ratio;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R11 reset reg", v, 8'h00);
    end
    chk("R11 reset pins", {5'd0, cmp_pin, ovf_irq, cmp_irq}, 8'h00);

    // R11 readback
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R11 ctrl bit7 reads 0", v, 8'h7F);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hA5); rd(2'd2, v); chk("R11 compare readback", v, 8'hA5);
    wr(2'd2, 8'h00);

    // R1 stopped: prescaler and pin activity leave count alone
    wr(2'd1, 8'h33);
    repeat (50) @(negedge clk);
    pulses(3);
    rd(2'd1, v); chk("R1 stopped count", v, 8'h33);

    // R2 every clock
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    repeat (100) @(negedge clk);
    rd(2'd1, v); chk("R2 div1 steps", v, 8'd100);
    wr(2'd0, 8'h00);

    // R3 divided rates over a 1024-clock window
    for (int code = 2; code <= 5; code++) begin
      ratio = (code == 2) ? 8 : (code == 3) ? 64 : (code == 4) ? 256 : 1024;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'(code));
      repeat (1024) @(negedge clk);
      rd(2'd1, v); chk($sformatf("R3 code %0d", code), v, 8'(1024 / ratio));
    end
    wr(2'd0, 8'h00);

    // R4 rising and falling pin edges
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    pulses(5);
    rd(2'd1, v); chk("R4 rising edges", v, 8'd5);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h06);
    pulses(7);
    rd(2'd1, v); chk("R4 falling edges", v, 8'h17);
    wr(2'd0, 8'h00);

    // R5 and R8 overflow exact cycle
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h40);
    wr(2'd1, 8'hFD);
    wr(2'd0, 8'h21);
    repeat (2) @(negedge clk);
    rd(2'd3, v); chk("R5 flag not yet at FF", v, 8'h00);
    @(negedge clk);
    rd(2'd3, v); chk("R5 flag on wrap", v, 8'h01);
    rd(2'd1, v); chk("R5 count wrapped", v, 8'h00);
    chk("R8 ovf irq enabled", {7'd0, ovf_irq}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R8 ovf irq masked", {7'd0, ovf_irq}, 8'h00);

    // R7 write-one clear leaves other flag
    wr(2'd3, 8'h02);
    rd(2'd3, v); chk("R7 write 0 keeps ovf", v, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R7 write 1 clears ovf", v, 8'h00);

    // R6 and R8 compare exact cycle
    wr(2'd2, 8'h14);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h41);
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk("R6 flag before match", v, 8'h00);
    @(negedge clk);
    rd(2'd3, v); chk("R6 flag on match", v, 8'h02);
    chk("R8 cmp irq", {7'd0, cmp_irq}, 8'h01);
    wr(2'd0, 8'h40);
    cmp_ack = 1'b1; @(negedge clk); cmp_ack = 1'b0;
    rd(2'd3, v); chk("R7 ack clears cmp", v, 8'h00);

    // R7 set wins over ack in the same cycle
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFD);
    wr(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    ovf_ack = 1'b1; @(negedge clk); ovf_ack = 1'b0;
    rd(2'd3, v); chk("R7 set beats ack", v, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h03);

    // R10 count write beats the step, suppresses flags
    wr(2'd2, 8'h55);
    wr(2'd1, 8'hFD);
    wr(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h55);
    rd(2'd1, v); chk("R10 write value lands", v, 8'h55);
    rd(2'd3, v); chk("R10 no flags from write", v, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h03);

    // R9 pin actions
    match_once(2'b11); chk("R9 set", {7'd0, cmp_pin}, 8'h01);
    match_once(2'b10); chk("R9 clear", {7'd0, cmp_pin}, 8'h00);
    match_once(2'b01); chk("R9 toggle up", {7'd0, cmp_pin}, 8'h01);
    match_once(2'b01); chk("R9 toggle down", {7'd0, cmp_pin}, 8'h00);
    match_once(2'b11);
    match_once(2'b00); chk("R9 off reads 0", {7'd0, cmp_pin}, 8'h00);
    wr(2'd0, 8'h08);   chk("R9 held state", {7'd0, cmp_pin}, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule